// File: doc/BRIEF.md
# Flash Controller Command and Interrupt Register Block

This block holds the control-plane registers of a memory-mapped flash controller: the command register, the interrupt-status register, the controller-status (error) register and two system-configuration registers. Software reaches them through a simple single-cycle write port and a combinational read port. The flash command engine, which is outside this block, receives each accepted command as a one-cycle `cmd_go` pulse with the code on `cmd_code`. It reports completions and failures back through a single-cycle event pulse.

Command issue is handshaked through the interrupt register. A new command is taken only while the master interrupt bit is clear. Software acknowledges by writing a mask that is ANDed into the interrupt status. Dropping the master bit also wipes the latched error flags. The interrupt pin polarity and the ready pin level both come from configuration register 1. A cold reset (`rst_n`) and a warm reset (`warm_rst` pin, or either reset command code) leave different interrupt-status values behind.

Top module: `flashreg_ctrl`

Register selects on `wr_sel`/`rd_sel`: 0 command, 1 configuration 1, 2 configuration 2, 3 controller status, 4 interrupt status. Unused selects read as zero and ignore writes.

## Requirements
- R1: After a cold reset the command register reads 0x0000, configuration 1 reads 0x40C0, configuration 2 reads 0x0000, status reads 0x0000 and interrupt status reads 0x8080; `rdy` is 1 and `cmd_go` is 0.
- R2: A warm reset is caused by the `warm_rst` pin or by an accepted command code 0x00F0 or 0x00F3. It sets the command register to 0, configuration 1 to 0x40C0, configuration 2 to 0, status to 0, interrupt status to 0x8010, and `rdy` to 1, with no `cmd_go`.
- R3: A write to the command register while interrupt-status bit 15 is set is ignored: `cmd_code` keeps its value and no `cmd_go` pulse occurs.
- R4: An accepted write of a known code (0x0000, 0x0013, 0x0080, 0x001A, 0x001B, 0x0023, 0x0027, 0x002A, 0x002C, 0x0030, 0x0065, 0x0071, 0x0094, 0x0095, 0x00B0) stores the code on `cmd_code` and gives a one-cycle `cmd_go` in the cycle after the write, without touching status or interrupt status.
- R5: An accepted write of any other code, including any code with a nonzero upper byte, is stored on `cmd_code`, sets status bit 10 and interrupt bit 15, and gives no `cmd_go`.
- R6: A write to interrupt status replaces it with the bitwise AND of its contents and the written value.
- R7: When interrupt bit 15 is clear after such a write, status bits 13:10 are all cleared; when it stays set, status is unchanged.
- R8: An event pulse (`evt_valid`) sets interrupt bit 15 plus a bit chosen by `evt_kind`: 0 none, 1 bit 5 (erase), 2 bit 6 (program), 3 bit 7 (load).
- R9: An event pulse with `evt_err` set also sets status bit 10 plus, by `evt_kind`, bit 11 (1, erase), bit 12 (2, program) or bit 13 (3, load).
- R10: `irq` equals interrupt bit 15 XOR the inverse of configuration-1 bit 6 (bit 6 set: active-high; clear: active-low).
- R11: A write to configuration 1 sets `rdy` to the written bit 7.
- R12: Reading configuration 1 returns the stored value with bits 4:0 forced to zero; configuration 2 reads back exactly as written.
- R13: If a write to interrupt status and an event arrive in the same cycle, the AND and the error clear of R7 are applied first, then the event bits of R8 and R9 are ORed in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Cold reset, active low, asynchronous |
| warm_rst | input | 1 | Warm reset request, synchronous, active high |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for the write |
| wr_data | input | 16 | Write data |
| rd_sel | input | 3 | Register select for the read |
| rd_data | output | 16 | Read data, combinational from registered state |
| evt_valid | input | 1 | Completion event pulse from the command engine |
| evt_kind | input | 2 | Event type: 0 none, 1 erase, 2 program, 3 load |
| evt_err | input | 1 | Event carries a failure |
| cmd_go | output | 1 | One-cycle pulse for an accepted known command |
| cmd_code | output | 16 | Current command register |
| irq | output | 1 | Interrupt, polarity from configuration 1 bit 6 |
| rdy | output | 1 | Ready level, from configuration 1 bit 7 |

## Verification
Every register update lands on the clock edge that captures the write or event, so read data, `irq`, `rdy`, `cmd_code` and the `cmd_go` pulse are all due one edge after the stimulus cycle. `cmd_go` must fall again at the edge after that. The bench drives each stimulus just after an edge and checks all results one time unit after the following edge. It then steps one more edge to check that `cmd_go` has dropped. Whole-space sweeps cover every low-byte command code, every interrupt-mask combination over the settable bits, and every event kind with and without error. The same-cycle write-and-event order is checked with directed cases.

// File: rtl/flashreg_pkg.sv
package flashreg_pkg;
  localparam int REG_W = 16;
  localparam int SEL_W = 3;
  localparam int KIND_W = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_CMD  = 3'd0,
    SEL_CFG1 = 3'd1,
    SEL_CFG2 = 3'd2,
    SEL_STAT = 3'd3,
    SEL_INT  = 3'd4
  } reg_sel_e;

  typedef enum logic [KIND_W-1:0] {
    EV_NONE  = 2'd0,
    EV_ERASE = 2'd1,
    EV_PROG  = 2'd2,
    EV_LOAD  = 2'd3
  } ev_kind_e;

  localparam int INT_MASTER = 15;
  localparam int INT_EV_BASE = 4;
  localparam int ST_CMD = 10;
  localparam int CFG1_POL = 6;
  localparam int CFG1_RDY = 7;
  localparam int CFG1_RD_LSB = 5;

  localparam logic [REG_W-1:0] CFG1_RST = 16'h40C0;
  localparam logic [REG_W-1:0] CFG2_RST = 16'h0000;
  localparam logic [REG_W-1:0] INT_COLD = 16'h8080;
  localparam logic [REG_W-1:0] INT_WARM = 16'h8010;
  localparam logic [REG_W-1:0] ERR_MASK = 16'h3C00;
  localparam logic [REG_W-1:0] CFG1_RD_MASK = ~((REG_W'(1) << CFG1_RD_LSB) - REG_W'(1));

  function automatic logic [REG_W-1:0] kind_int_bit(input logic [KIND_W-1:0] k);
    return (k == '0) ? '0 : (REG_W'(1) << (INT_EV_BASE + int'(k)));
  endfunction

  function automatic logic [REG_W-1:0] kind_err_bit(input logic [KIND_W-1:0] k);
    return (k == '0) ? '0 : (REG_W'(1) << (ST_CMD + int'(k)));
  endfunction
endpackage

// File: rtl/flashreg_cmd_decode.sv
module flashreg_cmd_decode
  import flashreg_pkg::*;
(
  input  logic [REG_W-1:0] code,
  output logic             known,
  output logic             is_reset
);
  logic upper_zero;
  assign upper_zero = (code[REG_W-1:8] == '0);

  always_comb begin
    known    = 1'b0;
    is_reset = 1'b0;
    if (upper_zero) begin
      case (code[7:0])
        8'h00, 8'h13, 8'h80, 8'h1A, 8'h1B,
        8'h23, 8'h27, 8'h2A, 8'h2C, 8'h30,
        8'h65, 8'h71, 8'h94, 8'h95, 8'hB0: known = 1'b1;
        8'hF0, 8'hF3:                      is_reset = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/flashreg_cfg.sv
module flashreg_cfg
  import flashreg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             warm,
  input  logic             wr_cfg1,
  input  logic             wr_cfg2,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] cfg1_q,
  output logic [REG_W-1:0] cfg2_q,
  output logic             rdy_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg1_q <= CFG1_RST;
      cfg2_q <= CFG2_RST;
      rdy_q  <= 1'b1;
    end else if (warm) begin
      cfg1_q <= CFG1_RST;
      cfg2_q <= CFG2_RST;
      rdy_q  <= 1'b1;
    end else begin
      if (wr_cfg1) begin
        cfg1_q <= wr_data;
        rdy_q  <= wr_data[CFG1_RDY];
      end
      if (wr_cfg2) cfg2_q <= wr_data;
    end
  end
endmodule

// File: rtl/flashreg_events.sv
module flashreg_events
  import flashreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              warm,
  input  logic              wr_int,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              unk_cmd,
  input  logic              evt_valid,
  input  logic [KIND_W-1:0] evt_kind,
  input  logic              evt_err,
  output logic [REG_W-1:0]  int_q,
  output logic [REG_W-1:0]  stat_q
);
  logic [REG_W-1:0] int_masked;
  logic [REG_W-1:0] int_n;
  logic [REG_W-1:0] stat_n;

  always_comb begin
    int_masked = wr_int ? (int_q & wr_data) : int_q;
    stat_n     = stat_q;
    if (wr_int && !int_masked[INT_MASTER]) stat_n = stat_n & ~ERR_MASK;
    int_n = int_masked;
    if (unk_cmd) begin
      int_n[INT_MASTER] = 1'b1;
      stat_n[ST_CMD]    = 1'b1;
    end
    if (evt_valid) begin
      int_n[INT_MASTER] = 1'b1;
      int_n = int_n | kind_int_bit(evt_kind);
      if (evt_err) begin
        stat_n[ST_CMD] = 1'b1;
        stat_n = stat_n | kind_err_bit(evt_kind);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_q  <= INT_COLD;
      stat_q <= '0;
    end else if (warm) begin
      int_q  <= INT_WARM;
      stat_q <= '0;
    end else begin
      int_q  <= int_n;
      stat_q <= stat_n;
    end
  end
endmodule

// File: rtl/flashreg_ctrl.sv
module flashreg_ctrl
  import flashreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              warm_rst,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [REG_W-1:0]  rd_data,
  input  logic              evt_valid,
  input  logic [KIND_W-1:0] evt_kind,
  input  logic              evt_err,
  output logic              cmd_go,
  output logic [REG_W-1:0]  cmd_code,
  output logic              irq,
  output logic              rdy
);
  logic [REG_W-1:0] cmd_q;
  logic [REG_W-1:0] cfg1_q;
  logic [REG_W-1:0] cfg2_q;
  logic [REG_W-1:0] int_q;
  logic [REG_W-1:0] stat_q;
  logic             go_q;
  logic             code_known;
  logic             code_reset;
  logic             cmd_accept;
  logic             warm;

  flashreg_cmd_decode u_dec (
    .code     (wr_data),
    .known    (code_known),
    .is_reset (code_reset)
  );

  // Acceptance looks at the master bit as it stands before this cycle's edge.
  assign cmd_accept = wr_en && (wr_sel == SEL_CMD) && !int_q[INT_MASTER];
  assign warm       = warm_rst || (cmd_accept && code_reset);

  flashreg_cfg u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .warm    (warm),
    .wr_cfg1 (wr_en && (wr_sel == SEL_CFG1)),
    .wr_cfg2 (wr_en && (wr_sel == SEL_CFG2)),
    .wr_data (wr_data),
    .cfg1_q  (cfg1_q),
    .cfg2_q  (cfg2_q),
    .rdy_q   (rdy)
  );

  flashreg_events u_evt (
    .clk       (clk),
    .rst_n     (rst_n),
    .warm      (warm),
    .wr_int    (wr_en && (wr_sel == SEL_INT)),
    .wr_data   (wr_data),
    .unk_cmd   (cmd_accept && !code_known && !code_reset),
    .evt_valid (evt_valid),
    .evt_kind  (evt_kind),
    .evt_err   (evt_err),
    .int_q     (int_q),
    .stat_q    (stat_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
      go_q  <= 1'b0;
    end else if (warm) begin
      cmd_q <= '0;
      go_q  <= 1'b0;
    end else begin
      go_q <= cmd_accept && code_known;
      if (cmd_accept) cmd_q <= wr_data;
    end
  end

  always_comb begin
    case (rd_sel)
      SEL_CMD:  rd_data = cmd_q;
      SEL_CFG1: rd_data = cfg1_q & CFG1_RD_MASK;
      SEL_CFG2: rd_data = cfg2_q;
      SEL_STAT: rd_data = stat_q;
      SEL_INT:  rd_data = int_q;
      default:  rd_data = '0;
    endcase
  end

  assign cmd_go   = go_q;
  assign cmd_code = cmd_q;
  assign irq      = int_q[INT_MASTER] ^ ~cfg1_q[CFG1_POL];
endmodule

// File: rtl/flashreg_ctrl_chk.sv
module flashreg_ctrl_chk
  import flashreg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              warm_rst,
  input logic              wr_en,
  input logic [SEL_W-1:0]  wr_sel,
  input logic [REG_W-1:0]  wr_data,
  input logic              evt_valid,
  input logic              evt_err,
  input logic              irq,
  input logic              rdy,
  input logic              cmd_go,
  input logic [REG_W-1:0]  cmd_code,
  input logic [REG_W-1:0]  int_q,
  input logic [REG_W-1:0]  stat_q,
  input logic [REG_W-1:0]  cfg1_q
);
  logic wr_int_clean;
  assign wr_int_clean = wr_en && (wr_sel == SEL_INT) && !evt_valid && !warm_rst;

  // R3
  a_r3_cmd_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_CMD && int_q[INT_MASTER] && !warm_rst)
      |=> (!cmd_go && $stable(cmd_code)));

  // R6
  a_r6_and_mask: assert property (@(posedge clk) disable iff (!rst_n)
    wr_int_clean |=> ((int_q & ~$past(wr_data)) == '0));

  // R7
  a_r7_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_int_clean && !wr_data[INT_MASTER]) |=> (stat_q[13:10] == 4'd0));

  // R8
  a_r8_event_master: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !warm_rst) |=> int_q[INT_MASTER]);

  // R9
  a_r9_event_error: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_err && !warm_rst) |=> stat_q[ST_CMD]);

  // R10
  a_r10_active_high: assert property (@(posedge clk) disable iff (!rst_n)
    cfg1_q[CFG1_POL] |-> (irq == int_q[INT_MASTER]));

  // R11
  a_r11_rdy_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_CFG1 && !warm_rst) |=> (rdy == $past(wr_data[CFG1_RDY])));
endmodule

bind flashreg_ctrl flashreg_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .warm_rst  (warm_rst),
  .wr_en     (wr_en),
  .wr_sel    (wr_sel),
  .wr_data   (wr_data),
  .evt_valid (evt_valid),
  .evt_err   (evt_err),
  .irq       (irq),
  .rdy       (rdy),
  .cmd_go    (cmd_go),
  .cmd_code  (cmd_code),
  .int_q     (int_q),
  .stat_q    (stat_q),
  .cfg1_q    (cfg1_q)
);

// File: tb/sim_flashreg_ctrl.sv
module sim_flashreg_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        warm_rst = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_sel = '0;
  logic [15:0] rd_data;
  logic        evt_valid = 1'b0;
  logic [1:0]  evt_kind = '0;
  logic        evt_err = 1'b0;
  logic        cmd_go;
  logic [15:0] cmd_code;
  logic        irq;
  logic        rdy;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flashreg_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data),
    .evt_valid(evt_valid), .evt_kind(evt_kind), .evt_err(evt_err),
    .cmd_go(cmd_go), .cmd_code(cmd_code), .irq(irq), .rdy(rdy)
  );

  localparam logic [2:0] S_CMD = 3'd0, S_CFG1 = 3'd1, S_CFG2 = 3'd2,
                         S_STAT = 3'd3, S_INT = 3'd4;

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic rd_chk(input logic [2:0] s, input logic [15:0] exp, input string tag);
    rd_sel = s;
    #1;
    chk(tag, rd_data, exp);
  endtask

  // One stimulus cycle; returns one unit after the capturing edge.
  task automatic step(input bit w, input logic [2:0] s, input logic [15:0] d,
                      input bit e, input logic [1:0] k, input bit er);
    @(posedge clk); #1;
    wr_en = w; wr_sel = s; wr_data = d;
    evt_valid = e; evt_kind = k; evt_err = er;
    @(posedge clk); #1;
    wr_en = 1'b0; evt_valid = 1'b0; evt_err = 1'b0;
  endtask

  task automatic wr(input logic [2:0] s, input logic [15:0] d);
    step(1'b1, s, d, 1'b0, 2'd0, 1'b0);
  endtask

  task automatic ev(input logic [1:0] k, input bit er);
    step(1'b0, 3'd0, 16'h0, 1'b1, k, er);
  endtask

  task automatic warm_pulse();
    @(posedge clk); #1; warm_rst = 1'b1;
    @(posedge clk); #1; warm_rst = 1'b0;
  endtask

  function automatic bit known_code(input logic [15:0] c);
    if (c[15:8] != 8'h00) return 1'b0;
    case (c[7:0])
      8'h00, 8'h13, 8'h80, 8'h1A, 8'h1B, 8'h23, 8'h27, 8'h2A,
      8'h2C, 8'h30, 8'h65, 8'h71, 8'h94, 8'h95, 8'hB0: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] cfgv [6];
    cfgv[0] = 16'h0000; cfgv[1] = 16'hFFFF; cfgv[2] = 16'h1234;
    cfgv[3] = 16'h00BF; cfgv[4] = 16'h0080; cfgv[5] = 16'h40DF;

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    // R1 cold reset state
    rd_chk(S_CMD, 16'h0000, "R1 cmd");
    rd_chk(S_CFG1, 16'h40C0, "R1 cfg1");
    rd_chk(S_CFG2, 16'h0000, "R1 cfg2");
    rd_chk(S_STAT, 16'h0000, "R1 status");
    rd_chk(S_INT, 16'h8080, "R1 int");
    chk("R1 rdy", {15'd0, rdy}, 16'd1);
    chk("R1 cmd_go", {15'd0, cmd_go}, 16'd0);
    chk("R10 irq at reset", {15'd0, irq}, 16'd1);

    // R3 command blocked while master set
    wr(S_CMD, 16'h0094);
    chk("R3 cmd_go", {15'd0, cmd_go}, 16'd0);
    chk("R3 cmd_code", cmd_code, 16'h0000);
    rd_chk(S_INT, 16'h8080, "R3 int");

    // R2 warm reset by pin
    wr(S_CFG2, 16'h1234);
    wr(S_CFG1, 16'h0000);
    chk("R11 rdy low", {15'd0, rdy}, 16'd0);
    warm_pulse();
    rd_chk(S_CFG1, 16'h40C0, "R2 cfg1");
    rd_chk(S_CFG2, 16'h0000, "R2 cfg2");
    rd_chk(S_INT, 16'h8010, "R2 int");
    rd_chk(S_STAT, 16'h0000, "R2 status");
    chk("R2 rdy", {15'd0, rdy}, 16'd1);

    // R6 / R7 mask sweep over settable interrupt bits
    for (int m = 0; m < 32; m++) begin
      logic [15:0] mask;
      warm_pulse();
      ev(2'd1, 1'b0);
      ev(2'd2, 1'b0);
      ev(2'd3, 1'b1);
      if (m == 0) begin
        rd_chk(S_INT, 16'h80F0, "R8 accumulated");
        rd_chk(S_STAT, 16'h2400, "R9 load error");
      end
      mask = (m[4] ? 16'h8000 : 16'h0000) | (16'(m[3:0]) << 4);
      wr(S_INT, mask);
      rd_chk(S_INT, 16'h80F0 & mask, "R6 and-mask");
      rd_chk(S_STAT, m[4] ? 16'h2400 : 16'h0000, "R7 error clear");
    end

    // R8 / R9 event kinds
    for (int k = 0; k < 4; k++) begin
      for (int e = 0; e < 2; e++) begin
        wr(S_INT, 16'h0000);
        rd_chk(S_STAT, 16'h0000, "R7 cleared");
        ev(2'(k), e[0]);
        rd_chk(S_INT, 16'h8000 | ((k == 0) ? 16'h0 : (16'h0010 << k)), "R8 event bits");
        rd_chk(S_STAT, e[0] ? (16'h0400 | (16'h0400 << k)) : 16'h0000, "R9 error bits");
      end
    end

    // R4 / R5 / R2 command code sweep
    for (int i = 0; i < 258; i++) begin
      logic [15:0] c;
      c = (i < 256) ? 16'(i) : ((i == 256) ? 16'h0100 : 16'h8094);
      wr(S_INT, 16'h0000);
      wr(S_CMD, c);
      if (c == 16'h00F0 || c == 16'h00F3) begin
        chk("R2 reset cmd go", {15'd0, cmd_go}, 16'd0);
        chk("R2 reset cmd code", cmd_code, 16'h0000);
        rd_chk(S_INT, 16'h8010, "R2 reset cmd int");
        rd_chk(S_STAT, 16'h0000, "R2 reset cmd status");
      end else if (known_code(c)) begin
        chk("R4 go", {15'd0, cmd_go}, 16'd1);
        chk("R4 code", cmd_code, c);
        rd_chk(S_INT, 16'h0000, "R4 int");
        rd_chk(S_STAT, 16'h0000, "R4 status");
        @(posedge clk); #1;
        chk("R4 go one cycle", {15'd0, cmd_go}, 16'd0);
      end else begin
        chk("R5 go", {15'd0, cmd_go}, 16'd0);
        chk("R5 code", cmd_code, c);
        rd_chk(S_INT, 16'h8000, "R5 int");
        rd_chk(S_STAT, 16'h0400, "R5 status");
      end
    end

    // R10 polarity
    for (int b = 0; b < 2; b++) begin
      for (int p = 0; p < 2; p++) begin
        wr(S_CFG1, b[0] ? 16'h0040 : 16'h0000);
        wr(S_INT, 16'h0000);
        if (p != 0) ev(2'd0, 1'b0);
        chk("R10 irq", {15'd0, irq}, {15'd0, p[0] ^ ~b[0]});
      end
    end

    // R11 / R12 configuration readback
    for (int i = 0; i < 6; i++) begin
      wr(S_CFG1, cfgv[i]);
      rd_chk(S_CFG1, cfgv[i] & 16'hFFE0, "R12 cfg1 read mask");
      chk("R11 rdy", {15'd0, rdy}, {15'd0, cfgv[i][7]});
      wr(S_CFG2, ~cfgv[i]);
      rd_chk(S_CFG2, ~cfgv[i], "R12 cfg2 read");
    end

    // R13 same-cycle write and event
    wr(S_INT, 16'h0000);
    ev(2'd2, 1'b0);
    rd_chk(S_INT, 16'h8040, "R13 setup");
    step(1'b1, S_INT, 16'h0000, 1'b1, 2'd3, 1'b1);
    rd_chk(S_INT, 16'h8080, "R13 and then set");
    rd_chk(S_STAT, 16'h2400, "R13 clear then error");
    step(1'b1, S_INT, 16'h0000, 1'b1, 2'd1, 1'b0);
    rd_chk(S_INT, 16'h8020, "R13 and then set kind1");
    rd_chk(S_STAT, 16'h0000, "R13 clear no error");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule